// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block keeps the 13-bit instruction address of a small processor core and decides, once per clock, where that address goes next. The address can step forward by one, be reloaded in full from an 8-bit low byte plus a 5-bit high-bits latch, be reloaded by a jump or a call whose 11-bit target sits inside a page picked by two latch bits, be forced to the interrupt entry point, or be restored from a hardware return stack.

The return stack holds eight 13-bit entries in a ring. A call or an interrupt pushes the current address. A return pops the most recent entry. The ring never reports overflow or underflow: a ninth push silently replaces the oldest entry, and popping past the bottom returns whatever slot the wrapped pointer lands on. The upper address bits cannot be read directly. Software sees the low byte of the address and the latch.

The core's decoder drives the request strobes. When several strobes arrive in the same cycle, a fixed priority picks one. The latch write is independent of that choice.

Top module: `pcseq_core`

## Requirements
- R1: While reset is asserted, the address, the latch and the stack pointer are cleared, and every stack slot is cleared to 0000h.
- R2: An increment with no higher-priority request advances the address by one, modulo 2^13, so 1FFFh is followed by 0000h.
- R3: A low-byte write loads address bits 7:0 from wr_data_i and bits 12:8 from the latch as it was before this clock edge. A latch write in the same cycle does not affect that load.
- R4: A latch write stores wr_data_i[4:0] into the latch. The new value is visible on lat_rd_o after the edge, and the latch write alone leaves the address unchanged.
- R5: A jump loads address bits 10:0 from tgt_i and bits 12:11 from latch bits 4:3.
- R6: A call loads the address in the same way as a jump. It also pushes the address value held in the cycle of the request.
- R7: An interrupt request pushes the address value held in that cycle and loads 0004h.
- R8: A return loads the most recently pushed entry that has not yet been popped.
- R9: The stack is an 8-slot ring. A ninth push overwrites the slot of the first push, and a tenth push overwrites the slot of the second. Later pops walk back around the ring.
- R10: A pop on an empty stack returns the slot selected by the wrapped pointer. Directly after reset, that value is 0000h.
- R11: Priority, from highest to lowest, is: interrupt, return, call, jump, low-byte write, increment. A request that loses is ignored, and a losing call pushes nothing.
- R12: lo_rd_o always equals address bits 7:0. Pushes and pops never change the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Step the address by one |
| lo_wr_i | input | 1 | Write the address low byte (full reload with the latch) |
| lat_wr_i | input | 1 | Write the high-bits latch |
| wr_data_i | input | 8 | Data for low-byte and latch writes |
| jmp_i | input | 1 | Paged jump request |
| call_i | input | 1 | Paged call request |
| tgt_i | input | 11 | Jump or call target inside the page |
| ret_i | input | 1 | Return request (pop) |
| irq_i | input | 1 | Interrupt vector request (push) |
| pc_o | output | 13 | Current address |
| lo_rd_o | output | 8 | Readable low byte of the address |
| lat_rd_o | output | 5 | Readable high-bits latch |

## Verification
The bench builds the block with its default parameters: a 13-bit address, an 8-bit low byte, 11-bit targets and an 8-slot ring. With eight slots, ten nested calls followed by ten returns are enough to reach the overwrite-and-wrap behaviour. With a 13-bit address, loading 1FFEh through the latch and stepping twice reaches the counter wrap. A return issued straight after reset exercises the empty-pop path. Cycles with every strobe raised at once exercise each level of the priority order.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;

  // Operation selected for the address register in one cycle.
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_LDLO = 3'd2,
    OP_JUMP = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_IRQ  = 3'd6
  } pc_op_e;

  // Fixed priority: irq > ret > call > jump > low write > increment.
  function automatic pc_op_e pick_op(input logic irq, input logic ret,
                                     input logic call, input logic jmp,
                                     input logic ldlo, input logic inc);
    pc_op_e op;
    if (irq)       op = OP_IRQ;
    else if (ret)  op = OP_RET;
    else if (call) op = OP_CALL;
    else if (jmp)  op = OP_JUMP;
    else if (ldlo) op = OP_LDLO;
    else if (inc)  op = OP_INC;
    else           op = OP_HOLD;
    return op;
  endfunction

  function automatic logic op_pushes(input pc_op_e op);
    return (op == OP_CALL) || (op == OP_IRQ);
  endfunction

  function automatic logic op_pops(input pc_op_e op);
    return (op == OP_RET);
  endfunction

endpackage

// File: rtl/pcseq_arb.sv
`timescale 1ns/1ps
module pcseq_arb
  import pcseq_pkg::*;
(
  input  logic   inc_i,
  input  logic   lo_wr_i,
  input  logic   jmp_i,
  input  logic   call_i,
  input  logic   ret_i,
  input  logic   irq_i,
  output pc_op_e op_o,
  output logic   push_o,
  output logic   pop_o
);

  pc_op_e op_w;

  always_comb begin
    op_w   = pick_op(irq_i, ret_i, call_i, jmp_i, lo_wr_i, inc_i);
    push_o = op_pushes(op_w);
    pop_o  = op_pops(op_w);
  end

  assign op_o = op_w;

endmodule

// File: rtl/pcseq_stack.sv
`timescale 1ns/1ps
module pcseq_stack #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_val_i,
  output logic [PC_W-1:0] pop_val_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0]      ptr_q;
  logic [PTR_W-1:0]      rd_idx;
  logic [DEPTH*PC_W-1:0] slots_flat;

  // Ring pointer: advances on push, retreats on pop, wraps silently.
  function automatic logic [PTR_W-1:0] ring_step(input logic [PTR_W-1:0] p,
                                                 input logic fwd);
    logic [PTR_W:0] nxt;
    if (fwd) nxt = {1'b0, p} + 1'b1;
    else     nxt = {1'b0, p} + (PTR_W+1)'(DEPTH - 1);
    return PTR_W'(nxt % DEPTH);
  endfunction

  assign rd_idx = ring_step(ptr_q, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (push_i) begin
      ptr_q <= ring_step(ptr_q, 1'b1);
    end else if (pop_i) begin
      ptr_q <= rd_idx;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PC_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (push_i && (ptr_q == PTR_W'(g))) begin
        slot_q <= push_val_i;
      end
    end
    assign slots_flat[g*PC_W +: PC_W] = slot_q;
  end

  assign pop_val_o = slots_flat[rd_idx*PC_W +: PC_W];

endmodule

// File: rtl/pcseq_next.sv
`timescale 1ns/1ps
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int JMP_W   = 11,
  parameter int VEC_INT = 4
) (
  input  pc_op_e               op_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [PC_W-LO_W-1:0] lat_i,
  input  logic [LO_W-1:0]      data_i,
  input  logic [JMP_W-1:0]     tgt_i,
  input  logic [PC_W-1:0]      pop_val_i,
  output logic [PC_W-1:0]      pc_next_o
);

  localparam int LAT_W  = PC_W - LO_W;
  localparam int PAGE_W = PC_W - JMP_W;

  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] pc);
    return pc + 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] f_full(input logic [LAT_W-1:0] lat,
                                             input logic [LO_W-1:0] lo);
    return {lat, lo};
  endfunction

  function automatic logic [PC_W-1:0] f_paged(input logic [LAT_W-1:0] lat,
                                              input logic [JMP_W-1:0] tgt);
    return {lat[LAT_W-1 -: PAGE_W], tgt};
  endfunction

  always_comb begin
    unique case (op_i)
      OP_INC:            pc_next_o = f_step(pc_i);
      OP_LDLO:           pc_next_o = f_full(lat_i, data_i);
      OP_JUMP, OP_CALL:  pc_next_o = f_paged(lat_i, tgt_i);
      OP_RET:            pc_next_o = pop_val_i;
      OP_IRQ:            pc_next_o = PC_W'(VEC_INT);
      default:           pc_next_o = pc_i;
    endcase
  end

endmodule

// File: rtl/pcseq_core.sv
`timescale 1ns/1ps
module pcseq_core
  import pcseq_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int JMP_W   = 11,
  parameter int DEPTH   = 8,
  parameter int VEC_INT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_i,
  input  logic                 lo_wr_i,
  input  logic                 lat_wr_i,
  input  logic [LO_W-1:0]      wr_data_i,
  input  logic                 jmp_i,
  input  logic                 call_i,
  input  logic [JMP_W-1:0]     tgt_i,
  input  logic                 ret_i,
  input  logic                 irq_i,
  output logic [PC_W-1:0]      pc_o,
  output logic [LO_W-1:0]      lo_rd_o,
  output logic [PC_W-LO_W-1:0] lat_rd_o
);

  localparam int LAT_W = PC_W - LO_W;

  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  pc_next_w;
  logic [LAT_W-1:0] lat_q;
  pc_op_e           op_w;
  logic             push_w;
  logic             pop_w;
  logic [PC_W-1:0]  pop_val_w;

  pcseq_arb u_arb (
    .inc_i   (inc_i),
    .lo_wr_i (lo_wr_i),
    .jmp_i   (jmp_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .irq_i   (irq_i),
    .op_o    (op_w),
    .push_o  (push_w),
    .pop_o   (pop_w)
  );

  pcseq_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_w),
    .pop_i      (pop_w),
    .push_val_i (pc_q),
    .pop_val_o  (pop_val_w)
  );

  pcseq_next #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W), .VEC_INT(VEC_INT)) u_next (
    .op_i      (op_w),
    .pc_i      (pc_q),
    .lat_i     (lat_q),
    .data_i    (wr_data_i),
    .tgt_i     (tgt_i),
    .pop_val_i (pop_val_w),
    .pc_next_o (pc_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (lat_wr_i) lat_q <= wr_data_i[LAT_W-1:0];
  end

  assign pc_o     = pc_q;
  assign lo_rd_o  = pc_q[LO_W-1:0];
  assign lat_rd_o = lat_q;

endmodule

// File: rtl/pcseq_chk.sv
`timescale 1ns/1ps
module pcseq_chk #(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int JMP_W   = 11,
  parameter int VEC_INT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inc_i,
  input logic                 lo_wr_i,
  input logic                 lat_wr_i,
  input logic [LO_W-1:0]      wr_data_i,
  input logic                 jmp_i,
  input logic                 call_i,
  input logic [JMP_W-1:0]     tgt_i,
  input logic                 ret_i,
  input logic                 irq_i,
  input logic [PC_W-1:0]      pc_o,
  input logic [PC_W-LO_W-1:0] lat_rd_o,
  input logic [PC_W-1:0]      pop_val_w
);

  localparam int LAT_W  = PC_W - LO_W;
  localparam int PAGE_W = PC_W - JMP_W;

  logic only_inc, only_jmp;
  assign only_inc = inc_i && !lo_wr_i && !jmp_i && !call_i && !ret_i && !irq_i;
  assign only_jmp = jmp_i && !call_i && !ret_i && !irq_i;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0 && lat_rd_o == '0));

  // R2
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_inc |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr_i |=> lat_rd_o == $past(wr_data_i[LAT_W-1:0]));

  // R12
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_wr_i |=> $stable(lat_rd_o));

  // R5
  jump_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_jmp |=> (pc_o[JMP_W-1:0] == $past(tgt_i)) &&
                 (pc_o[PC_W-1:JMP_W] == $past(lat_rd_o[LAT_W-1 -: PAGE_W])));

  // R7
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> pc_o == PC_W'(VEC_INT));

  // R8
  return_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !irq_i) |=> pc_o == $past(pop_val_w));

endmodule

bind pcseq_core pcseq_chk #(
  .PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W), .VEC_INT(VEC_INT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inc_i     (inc_i),
  .lo_wr_i   (lo_wr_i),
  .lat_wr_i  (lat_wr_i),
  .wr_data_i (wr_data_i),
  .jmp_i     (jmp_i),
  .call_i    (call_i),
  .tgt_i     (tgt_i),
  .ret_i     (ret_i),
  .irq_i     (irq_i),
  .pc_o      (pc_o),
  .lat_rd_o  (lat_rd_o),
  .pop_val_w (pop_val_w)
);

// File: tb/pcseq_core_tb.sv
`timescale 1ns/1ps
module pcseq_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_i = 0, lo_wr_i = 0, lat_wr_i = 0, jmp_i = 0, call_i = 0;
  logic        ret_i = 0, irq_i = 0;
  logic [7:0]  wr_data_i = '0;
  logic [10:0] tgt_i = '0;
  logic [12:0] pc_o;
  logic [7:0]  lo_rd_o;
  logic [4:0]  lat_rd_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int m_pc, m_lat, m_ptr;
  int m_stk[8];

  always #5 clk = ~clk;

  pcseq_core u_dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .lo_wr_i(lo_wr_i),
    .lat_wr_i(lat_wr_i), .wr_data_i(wr_data_i), .jmp_i(jmp_i),
    .call_i(call_i), .tgt_i(tgt_i), .ret_i(ret_i), .irq_i(irq_i),
    .pc_o(pc_o), .lo_rd_o(lo_rd_o), .lat_rd_o(lat_rd_o)
  );

  task automatic compare(input string tag);
    checks++;
    if (int'(pc_o) != m_pc || int'(lo_rd_o) != (m_pc % 256) || int'(lat_rd_o) != m_lat) begin
      fails++;
      $display("FAIL %s: pc=%h lo=%h lat=%h expected pc=%h lo=%h lat=%h",
               tag, pc_o, lo_rd_o, lat_rd_o, m_pc[12:0], m_pc[7:0], m_lat[4:0]);
    end
  endtask

  task automatic m_push(input int v);
    m_stk[m_ptr] = v;
    m_ptr = (m_ptr + 1) % 8;
  endtask

  task automatic cyc(input bit inc, input bit lo, input bit lat, input bit jmp,
                     input bit call, input bit ret, input bit irq,
                     input int d, input int t, input string tag);
    int page;
    inc_i = inc; lo_wr_i = lo; lat_wr_i = lat; jmp_i = jmp;
    call_i = call; ret_i = ret; irq_i = irq;
    wr_data_i = d[7:0]; tgt_i = t[10:0];
    @(posedge clk);
    page = ((m_lat / 8) % 4) * 2048 + (t % 2048);
    if (irq) begin m_push(m_pc); m_pc = 4; end
    else if (ret) begin m_ptr = (m_ptr + 7) % 8; m_pc = m_stk[m_ptr]; end
    else if (call) begin m_push(m_pc); m_pc = page; end
    else if (jmp) m_pc = page;
    else if (lo) m_pc = m_lat * 256 + (d % 256);
    else if (inc) m_pc = (m_pc + 1) % 8192;
    if (lat) m_lat = d % 32;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0,0,0,0,0,0,0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    inc_i = 0; lo_wr_i = 0; lat_wr_i = 0; jmp_i = 0; call_i = 0; ret_i = 0; irq_i = 0;
    rst_n = 1'b0;
    m_pc = 0; m_lat = 0; m_ptr = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle("R1 after reset");

    // R2 sequential stepping
    for (int i = 0; i < 5; i++) cyc(1,0,0,0,0,0,0, 0, 0, "R2 step");

    // R4 latch write, then R3 full reload to 1FFEh, then R2 wrap
    cyc(0,0,1,0,0,0,0, 8'hFF, 0, "R4 latch write");
    cyc(0,1,0,0,0,0,0, 8'hFE, 0, "R3 low write");
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,0,0,0, 0, 0, "R2 wrap");

    // R5 paged jump: latch 0Ah gives page 01
    cyc(0,0,1,0,0,0,0, 8'h0A, 0, "R4 latch write");
    cyc(0,0,0,1,0,0,0, 0, 11'h123, "R5 jump");

    // R3 low write with same-cycle latch write: old latch used
    cyc(0,1,1,0,0,0,0, 8'h55, 0, "R3 low write old latch");

    // R6 call pushes, R8 return restores
    cyc(0,0,0,0,1,0,0, 0, 11'h200, "R6 call");
    cyc(1,0,0,0,0,0,0, 0, 0, "R2 step in callee");
    cyc(0,0,0,0,0,1,0, 0, 0, "R8 return");

    // R7 interrupt
    cyc(0,0,0,0,0,0,1, 0, 0, "R7 irq vector");
    cyc(1,0,0,0,0,0,0, 0, 0, "R2 step in handler");
    cyc(0,0,0,0,0,1,0, 0, 0, "R8 return from irq");

    // R11 priority ladder
    cyc(1,1,0,1,1,1,1, 8'h33, 11'h0AA, "R11 irq wins");
    cyc(1,1,0,1,1,1,0, 8'h33, 11'h0AA, "R11 ret wins");
    cyc(1,1,0,1,1,0,0, 8'h44, 11'h155, "R11 call wins");
    cyc(1,1,0,1,0,0,0, 8'h44, 11'h2AA, "R11 jump wins");
    cyc(1,1,0,0,0,0,0, 8'h66, 0, "R11 low write wins");
    cyc(0,0,0,0,0,1,0, 0, 0, "R11 ret after call");

    // R9 ring overwrite: ten calls from distinct places, then ten returns
    for (int i = 0; i < 10; i++) begin
      cyc(0,1,0,0,0,0,0, 16 * i + 3, 0, "R3 set call site");
      cyc(0,0,0,0,1,0,0, 0, 11'h7F0 + i, "R9 nested call");
    end
    for (int i = 0; i < 10; i++) cyc(0,0,0,0,0,1,0, 0, 0, "R9 ring return");
    cyc(0,0,1,0,1,0,0, 8'h1C, 11'h011, "R12 latch after pushes");
    cyc(0,0,0,0,0,1,0, 0, 0, "R12 latch after pop");

    // R10 empty pop after reset
    do_reset();
    cyc(0,0,0,0,0,1,0, 0, 0, "R10 empty pop");
    cyc(1,0,0,0,0,0,0, 0, 0, "R2 step after empty pop");
    cyc(0,0,0,0,0,1,0, 0, 0, "R10 second empty pop");
    idle("R12 idle");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule